// File: doc/BRIEF.md
# Isolation Group Freeze Filter

This block keeps a two-bit freeze record for every isolation group behind a host bridge and applies it to the traffic that belongs to those groups. Upstream logic has already worked out which group a transaction belongs to. The block receives each transaction with that group number and decides what happens to it. It is forwarded, discarded (for writes), or answered locally with an all-ones completion (for reads). Message-signalled interrupts from a group are forwarded or blocked in the same way.

Each group has two flags. One guards the outbound memory-mapped path, from the CPU to the device. The other guards the inbound DMA path, from the device to memory, and it also gates that group's interrupts. An error-event input freezes a group by setting both of its flags together. Software then thaws each direction on its own through a clear command that names the group and selects the flags to clear. A lookup port shows both flags of any chosen group. Each verdict is registered and appears one cycle after the transaction is presented. The verdict uses the flags as they stood before that clock edge.

Top module: `pe_freeze_filter`

## Requirements
- R1: After reset every group has both flags clear, and all verdict outputs (`ob_pass`, `ob_drop`, `ob_synth`, the matching inbound outputs, `msi_pass`, `msi_blocked`) are low.
- R2: A freeze event (`frz_vld` high with group `frz_grp`) sets both flags of that group at the next clock edge. `stat_mmio` and `stat_dma` read 1 for that group from then on.
- R3: A clear command (`clr_vld` with `clr_grp`) clears the outbound flag when `clr_mmio`=1 and the inbound flag when `clr_dma`=1. A flag whose select bit is 0 keeps its value.
- R4: When a freeze event and a clear command name the same group in the same cycle, both flags of that group end up set.
- R5: An outbound write (`ob_wr`=1) to a group whose outbound flag is set gives `ob_drop`=1 and `ob_pass`=0 one cycle later. Inbound writes are treated the same way against the inbound flag.
- R6: An outbound read (`ob_wr`=0) to a group whose outbound flag is set gives `ob_synth`=1 with `ob_rdata` all ones one cycle later, and `ob_pass`=0. Inbound reads are treated the same way against the inbound flag.
- R7: The outbound path looks only at the outbound flag, and the inbound path looks only at the inbound flag.
- R8: An interrupt (`msi_vld`) from a group whose inbound flag is set gives `msi_blocked`=1 and `msi_pass`=0 one cycle later. Otherwise it gives `msi_pass`=1.
- R9: A transaction to a group that is not frozen gives only the pass output one cycle later, with `*_synth`=0 and `*_rdata`=0.
- R10: A freeze event changes only the named group; other groups keep their flags.
- R11: A transaction presented in the same cycle as a freeze of its group is judged on the flags from before the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_vld | input | 1 | Freeze event strobe |
| frz_grp | input | GW | Group to freeze |
| clr_vld | input | 1 | Clear command strobe |
| clr_grp | input | GW | Group to clear |
| clr_mmio | input | 1 | Clear the outbound flag |
| clr_dma | input | 1 | Clear the inbound flag |
| stat_grp | input | GW | Group whose flags are shown |
| stat_mmio | output | 1 | Outbound flag of `stat_grp` |
| stat_dma | output | 1 | Inbound flag of `stat_grp` |
| ob_vld | input | 1 | Outbound transaction valid |
| ob_grp | input | GW | Outbound transaction group |
| ob_wr | input | 1 | 1 = write, 0 = read |
| ob_pass | output | 1 | Outbound transaction forwarded |
| ob_drop | output | 1 | Outbound write discarded |
| ob_synth | output | 1 | Outbound read completed locally |
| ob_rdata | output | DW | Local completion data (all ones when `ob_synth`) |
| ib_vld | input | 1 | Inbound transaction valid |
| ib_grp | input | GW | Inbound transaction group |
| ib_wr | input | 1 | 1 = write, 0 = read |
| ib_pass | output | 1 | Inbound transaction forwarded |
| ib_drop | output | 1 | Inbound write discarded |
| ib_synth | output | 1 | Inbound read completed locally |
| ib_rdata | output | DW | Local completion data (all ones when `ib_synth`) |
| msi_vld | input | 1 | Interrupt message valid |
| msi_grp | input | GW | Interrupt source group |
| msi_pass | output | 1 | Interrupt forwarded |
| msi_blocked | output | 1 | Interrupt suppressed |

## Verification
The hardest case to reach is a group with its two flags in different states. A freeze event always sets both flags, so only a clear command that selects one flag can split them. The stimulus freezes a group, clears a single direction, and then sends traffic on both paths and an interrupt. This shows that each path reads its own flag. A second hard case is a freeze colliding with a clear or with a transaction in the same cycle. The bench drives both strobes on the same clock edge and checks the result through the lookup port and the next verdict.

// File: rtl/pe_frz_pkg.sv
package pe_frz_pkg;

  // Registered fate of one transaction
  typedef enum logic [1:0] {
    VERD_IDLE  = 2'd0,
    VERD_PASS  = 2'd1,
    VERD_DROP  = 2'd2,
    VERD_SYNTH = 2'd3
  } verdict_e;

endpackage

// File: rtl/pe_frz_state.sv
module pe_frz_state #(
  parameter int NGRP = 256,
  localparam int GW = $clog2(NGRP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frz_vld,
  input  logic [GW-1:0] frz_grp,
  input  logic          clr_vld,
  input  logic [GW-1:0] clr_grp,
  input  logic          clr_mmio,
  input  logic          clr_dma,
  input  logic [GW-1:0] ob_grp,
  input  logic [GW-1:0] ib_grp,
  input  logic [GW-1:0] msi_grp,
  input  logic [GW-1:0] stat_grp,
  output logic          ob_frozen,
  output logic          ib_frozen,
  output logic          msi_frozen,
  output logic          stat_mmio,
  output logic          stat_dma
);

  logic [NGRP-1:0] mmio_q, mmio_d, mmio_en;
  logic [NGRP-1:0] dma_q, dma_d, dma_en;

  for (genvar g = 0; g < NGRP; g++) begin : g_entry
    logic hit_frz, hit_clr_m, hit_clr_d;

    // Next-state: a freeze wins over a clear to the same entry
    always_comb begin
      hit_frz    = frz_vld && (frz_grp == GW'(g));
      hit_clr_m  = clr_vld && clr_mmio && (clr_grp == GW'(g));
      hit_clr_d  = clr_vld && clr_dma  && (clr_grp == GW'(g));
      mmio_en[g] = hit_frz || hit_clr_m;
      dma_en[g]  = hit_frz || hit_clr_d;
      mmio_d[g]  = hit_frz;
      dma_d[g]   = hit_frz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mmio_q[g] <= 1'b0;
      end else if (mmio_en[g]) begin
        mmio_q[g] <= mmio_d[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dma_q[g] <= 1'b0;
      end else if (dma_en[g]) begin
        dma_q[g] <= dma_d[g];
      end
    end
  end

  // Lookup ports
  always_comb begin
    ob_frozen  = mmio_q[ob_grp];
    ib_frozen  = dma_q[ib_grp];
    msi_frozen = dma_q[msi_grp];
    stat_mmio  = mmio_q[stat_grp];
    stat_dma   = dma_q[stat_grp];
  end

endmodule

// File: rtl/pe_frz_gate.sv
module pe_frz_gate
  import pe_frz_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          wr,
  input  logic          frozen,
  output logic          pass,
  output logic          drop,
  output logic          synth,
  output logic [DW-1:0] rdata
);

  verdict_e verd_q, verd_d;

  always_comb begin
    if (!vld) begin
      verd_d = VERD_IDLE;
    end else if (!frozen) begin
      verd_d = VERD_PASS;
    end else if (wr) begin
      verd_d = VERD_DROP;
    end else begin
      verd_d = VERD_SYNTH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q <= VERD_IDLE;
    end else begin
      verd_q <= verd_d;
    end
  end

  always_comb begin
    pass  = (verd_q == VERD_PASS);
    drop  = (verd_q == VERD_DROP);
    synth = (verd_q == VERD_SYNTH);
    rdata = synth ? {DW{1'b1}} : {DW{1'b0}};
  end

endmodule

// File: rtl/pe_frz_msi_gate.sv
module pe_frz_msi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic frozen,
  output logic pass,
  output logic blocked
);

  logic pass_q, pass_d, blk_q, blk_d;

  always_comb begin
    pass_d = vld && !frozen;
    blk_d  = vld && frozen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      pass_q <= pass_d;
      blk_q  <= blk_d;
    end
  end

  assign pass    = pass_q;
  assign blocked = blk_q;

endmodule

// File: rtl/pe_freeze_filter.sv
module pe_freeze_filter #(
  parameter int NGRP = 256,
  parameter int DW   = 32,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frz_vld,
  input  logic [GW-1:0] frz_grp,
  input  logic          clr_vld,
  input  logic [GW-1:0] clr_grp,
  input  logic          clr_mmio,
  input  logic          clr_dma,
  input  logic [GW-1:0] stat_grp,
  output logic          stat_mmio,
  output logic          stat_dma,
  input  logic          ob_vld,
  input  logic [GW-1:0] ob_grp,
  input  logic          ob_wr,
  output logic          ob_pass,
  output logic          ob_drop,
  output logic          ob_synth,
  output logic [DW-1:0] ob_rdata,
  input  logic          ib_vld,
  input  logic [GW-1:0] ib_grp,
  input  logic          ib_wr,
  output logic          ib_pass,
  output logic          ib_drop,
  output logic          ib_synth,
  output logic [DW-1:0] ib_rdata,
  input  logic          msi_vld,
  input  logic [GW-1:0] msi_grp,
  output logic          msi_pass,
  output logic          msi_blocked
);

  logic ob_frozen, ib_frozen, msi_frozen;

  pe_frz_state #(.NGRP(NGRP)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .frz_vld   (frz_vld),
    .frz_grp   (frz_grp),
    .clr_vld   (clr_vld),
    .clr_grp   (clr_grp),
    .clr_mmio  (clr_mmio),
    .clr_dma   (clr_dma),
    .ob_grp    (ob_grp),
    .ib_grp    (ib_grp),
    .msi_grp   (msi_grp),
    .stat_grp  (stat_grp),
    .ob_frozen (ob_frozen),
    .ib_frozen (ib_frozen),
    .msi_frozen(msi_frozen),
    .stat_mmio (stat_mmio),
    .stat_dma  (stat_dma)
  );

  pe_frz_gate #(.DW(DW)) u_ob_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (ob_vld),
    .wr    (ob_wr),
    .frozen(ob_frozen),
    .pass  (ob_pass),
    .drop  (ob_drop),
    .synth (ob_synth),
    .rdata (ob_rdata)
  );

  pe_frz_gate #(.DW(DW)) u_ib_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (ib_vld),
    .wr    (ib_wr),
    .frozen(ib_frozen),
    .pass  (ib_pass),
    .drop  (ib_drop),
    .synth (ib_synth),
    .rdata (ib_rdata)
  );

  pe_frz_msi_gate u_msi_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (msi_vld),
    .frozen (msi_frozen),
    .pass   (msi_pass),
    .blocked(msi_blocked)
  );

endmodule

// File: rtl/pe_freeze_filter_chk.sv
module pe_freeze_filter_chk #(
  parameter int DW = 32,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frz_vld,
  input logic [GW-1:0] frz_grp,
  input logic [GW-1:0] stat_grp,
  input logic          stat_mmio,
  input logic          stat_dma,
  input logic          ob_vld,
  input logic          ob_wr,
  input logic          ob_frozen,
  input logic          ob_pass,
  input logic          ob_drop,
  input logic          ob_synth,
  input logic [DW-1:0] ob_rdata,
  input logic          ib_pass,
  input logic          ib_drop,
  input logic          ib_synth,
  input logic          msi_vld,
  input logic          msi_frozen,
  input logic          msi_pass,
  input logic          msi_blocked
);

  // R2
  freeze_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_vld |=> (($past(frz_grp) != stat_grp) || (stat_mmio && stat_dma)));

  // R5
  frozen_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_vld && ob_wr && ob_frozen) |=> (ob_drop && !ob_pass));

  // R6
  frozen_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_vld && !ob_wr && ob_frozen) |=> (ob_synth && (ob_rdata == {DW{1'b1}}) && !ob_pass));

  // R8
  msi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_vld && msi_frozen) |=> (msi_blocked && !msi_pass));

  // R9
  ob_one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ob_pass, ob_drop, ob_synth}));

  // R9
  ib_one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ib_pass, ib_drop, ib_synth}));

endmodule

bind pe_freeze_filter pe_freeze_filter_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frz_vld    (frz_vld),
  .frz_grp    (frz_grp),
  .stat_grp   (stat_grp),
  .stat_mmio  (stat_mmio),
  .stat_dma   (stat_dma),
  .ob_vld     (ob_vld),
  .ob_wr      (ob_wr),
  .ob_frozen  (ob_frozen),
  .ob_pass    (ob_pass),
  .ob_drop    (ob_drop),
  .ob_synth   (ob_synth),
  .ob_rdata   (ob_rdata),
  .ib_pass    (ib_pass),
  .ib_drop    (ib_drop),
  .ib_synth   (ib_synth),
  .msi_vld    (msi_vld),
  .msi_frozen (msi_frozen),
  .msi_pass   (msi_pass),
  .msi_blocked(msi_blocked)
);

// File: tb/pe_freeze_filter_bench.sv
module pe_freeze_filter_bench;

  localparam int NGRP = 256;
  localparam int DW   = 32;
  localparam int GW   = $clog2(NGRP);

  logic          clk, rst_n;
  logic          frz_vld, clr_vld, clr_mmio, clr_dma;
  logic [GW-1:0] frz_grp, clr_grp, stat_grp;
  logic          stat_mmio, stat_dma;
  logic          ob_vld, ob_wr, ob_pass, ob_drop, ob_synth;
  logic [GW-1:0] ob_grp;
  logic [DW-1:0] ob_rdata;
  logic          ib_vld, ib_wr, ib_pass, ib_drop, ib_synth;
  logic [GW-1:0] ib_grp;
  logic [DW-1:0] ib_rdata;
  logic          msi_vld, msi_pass, msi_blocked;
  logic [GW-1:0] msi_grp;

  int n_chk  = 0;
  int n_fail = 0;

  pe_freeze_filter #(.NGRP(NGRP), .DW(DW)) u_pe_freeze_filter (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    frz_vld = 0; frz_grp = '0; clr_vld = 0; clr_grp = '0;
    clr_mmio = 0; clr_dma = 0;
    ob_vld = 0; ob_grp = '0; ob_wr = 0;
    ib_vld = 0; ib_grp = '0; ib_wr = 0;
    msi_vld = 0; msi_grp = '0;
  endtask

  // Apply what is set up, clock once, return settled; then idle at negedge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic release_inputs();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic freeze(input int g);
    @(negedge clk);
    frz_vld = 1; frz_grp = GW'(g);
    tick();
    release_inputs();
  endtask

  task automatic clear(input int g, input bit m, input bit d);
    @(negedge clk);
    clr_vld = 1; clr_grp = GW'(g); clr_mmio = m; clr_dma = d;
    tick();
    release_inputs();
  endtask

  task automatic look(input int g, output bit m, output bit d);
    stat_grp = GW'(g);
    #0.5;
    m = stat_mmio; d = stat_dma;
  endtask

  task automatic t_reset();
    bit m, d;
    chk(!ob_pass && !ob_drop && !ob_synth && !ib_pass && !ib_drop && !ib_synth
        && !msi_pass && !msi_blocked, "R1 outputs idle",
        {ob_pass, ob_drop, ob_synth, ib_pass, ib_drop, ib_synth, msi_pass, msi_blocked}, 0);
    for (int g = 0; g < NGRP; g += 51) begin
      look(g, m, d);
      chk(!m && !d, "R1 flags clear", {m, d}, 0);
    end
  endtask

  task automatic t_unfrozen_pass();
    @(negedge clk);
    ob_vld = 1; ob_grp = 8'd3; ob_wr = 0;
    ib_vld = 1; ib_grp = 8'd4; ib_wr = 1;
    msi_vld = 1; msi_grp = 8'd5;
    tick();
    chk(ob_pass && !ob_synth && ob_rdata == 0, "R9 ob read passes", {ob_pass, ob_synth}, 2'b10);
    chk(ib_pass && !ib_drop, "R9 ib write passes", {ib_pass, ib_drop}, 2'b10);
    chk(msi_pass && !msi_blocked, "R8 msi passes when clear", {msi_pass, msi_blocked}, 2'b10);
    release_inputs();
  endtask

  task automatic t_freeze_and_gate();
    bit m, d;
    freeze(10);
    look(10, m, d);
    chk(m && d, "R2 both flags set", {m, d}, 2'b11);
    look(11, m, d);
    chk(!m && !d, "R10 neighbour untouched", {m, d}, 0);
    look(9, m, d);
    chk(!m && !d, "R10 neighbour untouched", {m, d}, 0);
    @(negedge clk);
    ob_vld = 1; ob_grp = 8'd10; ob_wr = 1;
    ib_vld = 1; ib_grp = 8'd10; ib_wr = 0;
    msi_vld = 1; msi_grp = 8'd10;
    tick();
    chk(ob_drop && !ob_pass, "R5 ob write dropped", {ob_drop, ob_pass}, 2'b10);
    chk(ib_synth && !ib_pass && ib_rdata == '1, "R6 ib read all ones", ib_rdata, '1);
    chk(msi_blocked && !msi_pass, "R8 msi blocked", {msi_blocked, msi_pass}, 2'b10);
    @(negedge clk);
    ob_wr = 0; ib_wr = 1; msi_vld = 0;
    tick();
    chk(ob_synth && !ob_pass && ob_rdata == '1, "R6 ob read all ones", ob_rdata, '1);
    chk(ib_drop && !ib_pass, "R5 ib write dropped", {ib_drop, ib_pass}, 2'b10);
    @(negedge clk);
    ob_grp = 8'd11; ib_vld = 0;
    tick();
    chk(ob_pass && !ob_synth, "R10 other group passes", {ob_pass, ob_synth}, 2'b10);
    release_inputs();
  endtask

  task automatic t_split_clear();
    bit m, d;
    clear(10, 0, 1);
    look(10, m, d);
    chk(m && !d, "R3 only inbound cleared", {m, d}, 2'b10);
    @(negedge clk);
    ob_vld = 1; ob_grp = 8'd10; ob_wr = 1;
    ib_vld = 1; ib_grp = 8'd10; ib_wr = 1;
    msi_vld = 1; msi_grp = 8'd10;
    tick();
    chk(ob_drop && !ob_pass, "R7 ob still frozen", {ob_drop, ob_pass}, 2'b10);
    chk(ib_pass && !ib_drop, "R7 ib thawed", {ib_pass, ib_drop}, 2'b10);
    chk(msi_pass && !msi_blocked, "R8 msi follows inbound flag", {msi_pass, msi_blocked}, 2'b10);
    release_inputs();
    clear(10, 1, 0);
    look(10, m, d);
    chk(!m && !d, "R3 outbound cleared", {m, d}, 0);
    freeze(20);
    clear(20, 1, 0);
    look(20, m, d);
    chk(!m && d, "R3 only outbound cleared", {m, d}, 2'b01);
    @(negedge clk);
    ob_vld = 1; ob_grp = 8'd20; ob_wr = 0;
    ib_vld = 1; ib_grp = 8'd20; ib_wr = 0;
    tick();
    chk(ob_pass && !ob_synth, "R7 ob thawed", {ob_pass, ob_synth}, 2'b10);
    chk(ib_synth && ib_rdata == '1, "R7 ib still frozen", ib_rdata, '1);
    release_inputs();
  endtask

  task automatic t_collision();
    bit m, d;
    @(negedge clk);
    frz_vld = 1; frz_grp = 8'd255;
    clr_vld = 1; clr_grp = 8'd255; clr_mmio = 1; clr_dma = 1;
    tick();
    release_inputs();
    look(255, m, d);
    chk(m && d, "R4 freeze wins over clear", {m, d}, 2'b11);
    @(negedge clk);
    frz_vld = 1; frz_grp = 8'd0;
    ob_vld = 1; ob_grp = 8'd0; ob_wr = 1;
    tick();
    chk(ob_pass && !ob_drop, "R11 same-cycle sees old state", {ob_pass, ob_drop}, 2'b10);
    @(negedge clk);
    frz_vld = 0;
    tick();
    chk(ob_drop && !ob_pass, "R11 next cycle sees freeze", {ob_drop, ob_pass}, 2'b10);
    release_inputs();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    stat_grp = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unfrozen_pass();
    t_freeze_and_gate();
    t_split_clear();
    t_collision();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule